// File: doc/BRIEF.md
# Profile Modulation Register Bank

This block keeps the control words of a group of synthesis channels in two layers. A serial write port fills a buffer layer: per channel a base frequency word, a base phase word, a base amplitude word, a modulation configuration and a table of sixteen profile words. The synthesis channels never see the buffer layer directly. They see an active layer that takes a copy of the whole buffer layer only when an update event occurs.

An update event is either a rising edge on the update input or any change of the four profile select pins. Both inputs are sampled once per period of a synchronisation clock that the block derives by dividing its system clock by four, and that clock is driven out so the driving logic can time its pins against it. The profile pins also pick which profile word replaces the modulated parameter (frequency, phase or amplitude). A modulation depth of 2, 4, 8 or 16 levels gives two-, four-, eight- or sixteen-level FSK, PSK or ASK.

Top module: `modbank_top`

## Requirements
- R1: `sync_clk_o` has a period of four `clk` cycles and is high for two of them; its rising edge marks the instant at which `upd_i` and `prof_i` are sampled.
- R2: A serial frame changes only the buffer layer. Outputs stay the same until an update event. A frame is 40 bits sent MSB first while `ser_cs_n` is low, shifted on rising `ser_clk`: an 8-bit address, then 32 data bits.
- R3: A rising edge on `upd_i` copies every buffer word of every channel into the active layer. Outputs change at the third `sync_clk_o` rising edge after the input changes between two such edges, and not at the second.
- R4: Holding `upd_i` high causes exactly one transfer. Frames written while it stays high do not reach the outputs until a new rising edge.
- R5: Any change in the value of `prof_i` causes the same transfer as an update edge, with the same latency.
- R6: The configuration word holds the target in bits [1:0] (0 none, 1 frequency, 2 phase, 3 amplitude) and the depth code in bits [3:2] (0, 1, 2, 3 for 2, 4, 8, 16 levels). The profile word whose index is `prof_i` masked to the lowest depth+1 bits replaces the target output.
- R7: Profile pins above the decoded depth do not change the selected word. A change on them still causes a transfer.
- R8: Phase uses the low 14 bits of the selected profile word and amplitude uses the low 10 bits. Outputs that are not the target show the active base words.
- R9: After reset every output word is zero.
- R10: A frame cut short by `ser_cs_n` rising before the 40th bit writes nothing. The next complete frame is accepted.
- R11: Address bits [7:5] name the channel, and a channel number with no channel is ignored. Bit 4 set selects a base word by bits [3:0]: 0 frequency, 1 phase, 2 amplitude, 3 configuration; other codes are ignored. Bit 4 clear writes profile word [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data in |
| upd_i | input | 1 | Update request, rising edge |
| prof_i | input | 4 | Profile select pins |
| sync_clk_o | output | 1 | System clock divided by four |
| freq_o | output | NCH*32 | Active frequency word per channel |
| phase_o | output | NCH*14 | Active phase word per channel |
| amp_o | output | NCH*10 | Active amplitude word per channel |

## Verification
An update or profile change driven just after a `sync_clk_o` rising edge passes through three sampling stages. The outputs show it after the third following rise and not after the second. The bench therefore drives pins 2 ns after a rise and samples 2 ns after the second and third rises, which checks both the hold and the change. A serial frame settles in the buffer within about six `clk` cycles of its last shift edge. The bench always leaves several cycles after raising `ser_cs_n` before the next update, so every buffered value counts as complete. Ignored stimuli are checked by a forced transfer and then the outputs.

// File: rtl/modbank_pkg.sv
package modbank_pkg;

  localparam int FREQ_W  = 32;
  localparam int PHASE_W = 14;
  localparam int AMP_W   = 10;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CH_LSB  = 5;
  localparam int CH_W    = ADDR_W - CH_LSB;
  localparam int CTL_BIT = 4;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FREQ  = 2'd1,
    TGT_PHASE = 2'd2,
    TGT_AMP   = 2'd3
  } mod_tgt_e;

  typedef struct packed {
    logic [1:0] depth;
    mod_tgt_e   tgt;
  } mod_cfg_t;

  localparam logic [3:0] SEL_FREQ  = 4'h0;
  localparam logic [3:0] SEL_PHASE = 4'h1;
  localparam logic [3:0] SEL_AMP   = 4'h2;
  localparam logic [3:0] SEL_CFG   = 4'h3;

endpackage

// File: rtl/modbank_sync_gen.sv
module modbank_sync_gen #(
  parameter int PROF_W   = 4,
  parameter int DIV_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [PROF_W-1:0] prof_i,
  output logic              sync_clk_o,
  output logic              load_o,
  output logic [PROF_W-1:0] sel_o
);

  logic [DIV_LOG2-1:0] div_q, div_d;
  logic                tick;
  logic [PROF_W-1:0]   pa_q, pb_q, pc_q, pa_d, pb_d, pc_d;
  logic                ua_q, ub_q, uc_q, ua_d, ub_d, uc_d;

  always_comb begin
    div_d = div_q + 1'b1;
    tick  = &div_q;
    pa_d  = pa_q;
    pb_d  = pb_q;
    pc_d  = pc_q;
    ua_d  = ua_q;
    ub_d  = ub_q;
    uc_d  = uc_q;
    if (tick) begin
      pa_d = prof_i;
      pb_d = pa_q;
      pc_d = pb_q;
      ua_d = upd_i;
      ub_d = ua_q;
      uc_d = ub_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pa_q  <= '0;
      pb_q  <= '0;
      pc_q  <= '0;
      ua_q  <= 1'b0;
      ub_q  <= 1'b0;
      uc_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      pa_q  <= pa_d;
      pb_q  <= pb_d;
      pc_q  <= pc_d;
      ua_q  <= ua_d;
      ub_q  <= ub_d;
      uc_q  <= uc_d;
    end
  end

  assign sync_clk_o = ~div_q[DIV_LOG2-1];
  assign load_o     = tick && ((pb_q != pc_q) || (ub_q && !uc_q));
  assign sel_o      = pb_q;

  // R1
  sync_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_clk_o) |=> $stable(sync_clk_o));

  // R1
  sync_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_clk_o) |=> $stable(sync_clk_o));

  // R4
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

endmodule

// File: rtl/modbank_ser_rx.sv
module modbank_ser_rx
  import modbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic               cs_m, cs_s, ck_m, ck_s, ck_p, d_m, d_s;
  logic               rise;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               wr_q, wr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_m <= 1'b1;
      cs_s <= 1'b1;
      ck_m <= 1'b0;
      ck_s <= 1'b0;
      ck_p <= 1'b0;
      d_m  <= 1'b0;
      d_s  <= 1'b0;
    end else begin
      cs_m <= cs_n_i;
      cs_s <= cs_m;
      ck_m <= sclk_i;
      ck_s <= ck_m;
      ck_p <= ck_s;
      d_m  <= sdi_i;
      d_s  <= d_m;
    end
  end

  assign rise = ck_s && !ck_p;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    wr_d  = 1'b0;
    if (cs_s) begin
      cnt_d = '0;
    end else if (rise && (cnt_q < CNT_W'(FRAME_W))) begin
      sh_d  = {sh_q[FRAME_W-2:0], d_s};
      cnt_d = cnt_q + 1'b1;
      wr_d  = (cnt_q == CNT_W'(FRAME_W - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      wr_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      wr_q  <= wr_d;
    end
  end

  assign wr_o   = wr_q;
  assign addr_o = sh_q[FRAME_W-1:DATA_W];
  assign data_o = sh_q[DATA_W-1:0];

  // R10
  frame_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W));

  // R10
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> !wr_o);

  // R10
  deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt_q == '0) && !wr_o);

endmodule

// File: rtl/modbank_chan.sv
module modbank_chan
  import modbank_pkg::*;
#(
  parameter int CH_ID  = 0,
  parameter int PROF_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               load_i,
  input  logic [PROF_W-1:0]  sel_i,
  output logic [FREQ_W-1:0]  freq_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [AMP_W-1:0]   amp_o
);

  localparam int NPROF = 1 << PROF_W;

  logic               hit, is_ctl;
  logic [3:0]         ctl_sel;
  logic [PROF_W-1:0]  widx;

  logic [FREQ_W-1:0]  bf_freq_q,  bf_freq_d,  ac_freq_q,  ac_freq_d;
  logic [PHASE_W-1:0] bf_phase_q, bf_phase_d, ac_phase_q, ac_phase_d;
  logic [AMP_W-1:0]   bf_amp_q,   bf_amp_d,   ac_amp_q,   ac_amp_d;
  mod_cfg_t           bf_cfg_q,   bf_cfg_d,   ac_cfg_q,   ac_cfg_d;
  logic [PROF_W-1:0]  ac_sel_q,   ac_sel_d;
  logic [DATA_W-1:0]  bf_prof_q [NPROF];
  logic [DATA_W-1:0]  bf_prof_d [NPROF];
  logic [DATA_W-1:0]  ac_prof_q [NPROF];
  logic [DATA_W-1:0]  ac_prof_d [NPROF];

  logic [PROF_W-1:0]  lvl_mask;
  logic [DATA_W-1:0]  pick;

  assign hit     = wr_i && (addr_i[ADDR_W-1:CH_LSB] == CH_W'(CH_ID));
  assign is_ctl  = addr_i[CTL_BIT];
  assign ctl_sel = addr_i[3:0];
  assign widx    = addr_i[PROF_W-1:0];

  // buffer layer next state
  always_comb begin
    bf_freq_d  = bf_freq_q;
    bf_phase_d = bf_phase_q;
    bf_amp_d   = bf_amp_q;
    bf_cfg_d   = bf_cfg_q;
    for (int i = 0; i < NPROF; i++) bf_prof_d[i] = bf_prof_q[i];
    if (hit) begin
      if (is_ctl) begin
        case (ctl_sel)
          SEL_FREQ:  bf_freq_d  = data_i[FREQ_W-1:0];
          SEL_PHASE: bf_phase_d = data_i[PHASE_W-1:0];
          SEL_AMP:   bf_amp_d   = data_i[AMP_W-1:0];
          SEL_CFG:   bf_cfg_d   = mod_cfg_t'(data_i[3:0]);
          default:   ;
        endcase
      end else begin
        bf_prof_d[widx] = data_i;
      end
    end
  end

  // active layer next state
  always_comb begin
    ac_freq_d  = ac_freq_q;
    ac_phase_d = ac_phase_q;
    ac_amp_d   = ac_amp_q;
    ac_cfg_d   = ac_cfg_q;
    ac_sel_d   = ac_sel_q;
    for (int i = 0; i < NPROF; i++) ac_prof_d[i] = ac_prof_q[i];
    if (load_i) begin
      ac_freq_d  = bf_freq_q;
      ac_phase_d = bf_phase_q;
      ac_amp_d   = bf_amp_q;
      ac_cfg_d   = bf_cfg_q;
      ac_sel_d   = sel_i;
      for (int i = 0; i < NPROF; i++) ac_prof_d[i] = bf_prof_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bf_freq_q  <= '0;
      bf_phase_q <= '0;
      bf_amp_q   <= '0;
      bf_cfg_q   <= '0;
      ac_freq_q  <= '0;
      ac_phase_q <= '0;
      ac_amp_q   <= '0;
      ac_cfg_q   <= '0;
      ac_sel_q   <= '0;
      for (int i = 0; i < NPROF; i++) begin
        bf_prof_q[i] <= '0;
        ac_prof_q[i] <= '0;
      end
    end else begin
      bf_freq_q  <= bf_freq_d;
      bf_phase_q <= bf_phase_d;
      bf_amp_q   <= bf_amp_d;
      bf_cfg_q   <= bf_cfg_d;
      ac_freq_q  <= ac_freq_d;
      ac_phase_q <= ac_phase_d;
      ac_amp_q   <= ac_amp_d;
      ac_cfg_q   <= ac_cfg_d;
      ac_sel_q   <= ac_sel_d;
      for (int i = 0; i < NPROF; i++) begin
        bf_prof_q[i] <= bf_prof_d[i];
        ac_prof_q[i] <= ac_prof_d[i];
      end
    end
  end

  // depth code d keeps the lowest d+1 select bits
  always_comb begin
    for (int b = 0; b < PROF_W; b++) lvl_mask[b] = (b <= int'(ac_cfg_q.depth));
  end

  assign pick = ac_prof_q[ac_sel_q & lvl_mask];

  always_comb begin
    freq_o  = ac_freq_q;
    phase_o = ac_phase_q;
    amp_o   = ac_amp_q;
    case (ac_cfg_q.tgt)
      TGT_FREQ:  freq_o  = pick[FREQ_W-1:0];
      TGT_PHASE: phase_o = pick[PHASE_W-1:0];
      TGT_AMP:   amp_o   = pick[AMP_W-1:0];
      default:   ;
    endcase
  end

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ac_freq_q) && $stable(ac_phase_q) && $stable(ac_amp_q)
                && $stable(ac_cfg_q) && $stable(ac_sel_q));

  // R2
  buffer_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && is_ctl && (ctl_sel == SEL_FREQ)) |=> (bf_freq_q == $past(data_i[FREQ_W-1:0])));

  // R11
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(bf_freq_q) && $stable(bf_phase_q) && $stable(bf_amp_q) && $stable(bf_cfg_q));

endmodule

// File: rtl/modbank_top.sv
module modbank_top
  import modbank_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int PROF_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_cs_n,
  input  logic                   ser_clk,
  input  logic                   ser_dat,
  input  logic                   upd_i,
  input  logic [PROF_W-1:0]      prof_i,
  output logic                   sync_clk_o,
  output logic [NCH*FREQ_W-1:0]  freq_o,
  output logic [NCH*PHASE_W-1:0] phase_o,
  output logic [NCH*AMP_W-1:0]   amp_o
);

  localparam int DIV_LOG2 = 2;

  logic              rst_m, rst_s;
  logic              wr;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic              load;
  logic [PROF_W-1:0] sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  modbank_ser_rx u_rx (
    .clk    (clk),
    .rst_n  (rst_s),
    .cs_n_i (ser_cs_n),
    .sclk_i (ser_clk),
    .sdi_i  (ser_dat),
    .wr_o   (wr),
    .addr_o (waddr),
    .data_o (wdata)
  );

  modbank_sync_gen #(
    .PROF_W   (PROF_W),
    .DIV_LOG2 (DIV_LOG2)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_s),
    .upd_i      (upd_i),
    .prof_i     (prof_i),
    .sync_clk_o (sync_clk_o),
    .load_o     (load),
    .sel_o      (sel)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    modbank_chan #(
      .CH_ID  (g),
      .PROF_W (PROF_W)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_s),
      .wr_i    (wr),
      .addr_i  (waddr),
      .data_i  (wdata),
      .load_i  (load),
      .sel_i   (sel),
      .freq_o  (freq_o[g*FREQ_W +: FREQ_W]),
      .phase_o (phase_o[g*PHASE_W +: PHASE_W]),
      .amp_o   (amp_o[g*AMP_W +: AMP_W])
    );
  end

endmodule

// File: tb/modbank_top_bench.sv
`timescale 1ns/1ps
module modbank_top_bench;

  localparam int NCH = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ser_cs_n, ser_clk, ser_dat, upd_i;
  logic [3:0]      prof_i;
  logic            sync_clk_o;
  logic [NCH*32-1:0] freq_o;
  logic [NCH*14-1:0] phase_o;
  logic [NCH*10-1:0] amp_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  modbank_top #(.NCH(NCH), .PROF_W(4)) u_modbank_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_cs_n   (ser_cs_n),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .upd_i      (upd_i),
    .prof_i     (prof_i),
    .sync_clk_o (sync_clk_o),
    .freq_o     (freq_o),
    .phase_o    (phase_o),
    .amp_o      (amp_o)
  );

  localparam logic [31:0] BF0 = 32'h1111_2222, BF1 = 32'h3333_4444;
  localparam logic [13:0] BP0 = 14'h0ABC,      BP1 = 14'h1234;
  localparam logic [9:0]  BA0 = 10'h155,       BA1 = 10'h2AA;

  // {pins, depth, target, expected index}
  localparam logic [11:0] VEC [8] = '{
    {4'h5, 2'd3, 2'd1, 4'h5},
    {4'hF, 2'd0, 2'd1, 4'h1},
    {4'h6, 2'd1, 2'd1, 4'h2},
    {4'hE, 2'd2, 2'd1, 4'h6},
    {4'h9, 2'd3, 2'd2, 4'h9},
    {4'hB, 2'd1, 2'd3, 4'h3},
    {4'hC, 2'd3, 2'd0, 4'h0},
    {4'hA, 2'd0, 2'd1, 4'h0}
  };

  function automatic logic [31:0] pw(input int k);
    return 32'h5A00_0200 + 32'(k) * 32'h0001_0101;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ch0();
    return {8'h0, freq_o[31:0], phase_o[13:0], amp_o[9:0]};
  endfunction

  function automatic logic [63:0] mk(input logic [31:0] f, input logic [13:0] p, input logic [9:0] a);
    return {8'h0, f, p, a};
  endfunction

  task automatic clk_step();
    @(posedge clk);
    #1;
  endtask

  task automatic sync_edge();
    @(posedge sync_clk_o);
    #2;
  endtask

  task automatic ser_bits(input logic [39:0] fr, input int nbits);
    ser_cs_n = 1'b0;
    for (int i = 39; i > 39 - nbits; i--) begin
      ser_dat = fr[i];
      repeat (3) clk_step();
      ser_clk = 1'b1;
      repeat (3) clk_step();
      ser_clk = 1'b0;
    end
    repeat (3) clk_step();
    ser_cs_n = 1'b1;
    repeat (6) clk_step();
  endtask

  task automatic ser_write(input logic [7:0] a, input logic [31:0] d);
    ser_bits({a, d}, 40);
  endtask

  // drive pins and an update edge together, sample at the third sync rise
  task automatic pulse(input logic [3:0] pins, input logic [63:0] exp, input string req);
    sync_edge();
    prof_i = pins;
    upd_i  = 1'b1;
    repeat (3) sync_edge();
    check(req, ch0(), exp);
    upd_i = 1'b0;
    repeat (2) sync_edge();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    realtime t0, t1, t2;
    logic [31:0] ef;
    logic [13:0] ep;
    logic [9:0]  ea;
    rst_n = 1'b0; ser_cs_n = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0;
    upd_i = 1'b0; prof_i = 4'h0;
    repeat (5) clk_step();
    rst_n = 1'b1;
    repeat (4) clk_step();

    // R9 reset state
    check("R9", {freq_o, phase_o[13:0], amp_o[9:0]}, 64'h0);
    check("R9 ch1", {36'h0, phase_o[27:14], amp_o[19:10]}, 64'h0);

    // R1 divided clock shape
    @(posedge sync_clk_o); t0 = $realtime;
    @(negedge sync_clk_o); t1 = $realtime;
    @(posedge sync_clk_o); t2 = $realtime;
    check("R1 period", 64'(int'(t2 - t0)), 64'd40);
    check("R1 high",   64'(int'(t1 - t0)), 64'd20);

    // load buffer layer
    for (int k = 0; k < 16; k++) ser_write(8'(k), pw(k));
    ser_write(8'h10, BF0); ser_write(8'h11, 32'(BP0)); ser_write(8'h12, 32'(BA0));
    ser_write(8'h30, BF1); ser_write(8'h31, 32'(BP1)); ser_write(8'h32, 32'(BA1));
    repeat (8) sync_edge();
    check("R2 buffered only", ch0(), 64'h0);

    // R3 latency of an update edge
    sync_edge();
    upd_i = 1'b1;
    repeat (2) sync_edge();
    check("R3 not before third rise", ch0(), 64'h0);
    sync_edge();
    check("R3 at third rise", ch0(), mk(BF0, BP0, BA0));
    check("R3 ch1", {8'h0, freq_o[63:32], phase_o[27:14], amp_o[19:10]}, mk(BF1, BP1, BA1));
    upd_i = 1'b0;
    repeat (2) sync_edge();

    // R6 R8 table of profile patterns
    foreach (VEC[v]) begin
      logic [3:0] pins = VEC[v][11:8];
      logic [1:0] dep  = VEC[v][7:6];
      logic [1:0] tgt  = VEC[v][5:4];
      int         idx  = int'(VEC[v][3:0]);
      ef = (tgt == 2'd1) ? pw(idx)        : BF0;
      ep = (tgt == 2'd2) ? pw(idx)[13:0]  : BP0;
      ea = (tgt == 2'd3) ? pw(idx)[9:0]   : BA0;
      ser_write(8'h13, {28'h0, dep, tgt});
      pulse(pins, mk(ef, ep, ea), "R6 R8 vector");
    end

    // R4 held update gives one transfer
    ser_write(8'h13, 32'h0);
    pulse(4'hA, mk(BF0, BP0, BA0), "R4 setup");
    sync_edge();
    upd_i = 1'b1;
    repeat (4) sync_edge();
    ser_write(8'h10, 32'h7777_0000);
    repeat (4) sync_edge();
    check("R4 held high", ch0(), mk(BF0, BP0, BA0));
    upd_i = 1'b0;
    repeat (2) sync_edge();
    pulse(4'hA, mk(32'h7777_0000, BP0, BA0), "R4 new edge");

    // R5 pin change alone transfers
    ser_write(8'h13, {28'h0, 2'd3, 2'd1});
    ser_write(8'h12, 32'h0F0);
    sync_edge();
    prof_i = 4'h3;
    repeat (2) sync_edge();
    check("R5 not before third rise", ch0(), mk(32'h7777_0000, BP0, BA0));
    sync_edge();
    check("R5 pin change", ch0(), mk(pw(3), BP0, 10'h0F0));

    // R7 undecoded pins
    ser_write(8'h13, {28'h0, 2'd0, 2'd1});
    sync_edge();
    prof_i = 4'h2;
    repeat (4) sync_edge();
    check("R7 two-level select", ch0(), mk(pw(0), BP0, 10'h0F0));
    ser_write(8'h12, 32'h033);
    sync_edge();
    prof_i = 4'hE;
    repeat (4) sync_edge();
    check("R7 upper pins ignored, transfer done", ch0(), mk(pw(0), BP0, 10'h033));

    // R10 aborted frame
    ser_bits({8'h12, 32'h0000_01FF}, 20);
    pulse(4'hE, mk(pw(0), BP0, 10'h033), "R10 aborted frame");
    ser_write(8'h12, 32'h044);
    pulse(4'hE, mk(pw(0), BP0, 10'h044), "R10 next frame");

    // R11 address decode
    ser_write(8'hE0, 32'hDEAD_BEEF);
    ser_write(8'h15, 32'hDEAD_BEEF);
    ser_write(8'h30, 32'h9999_0000);
    pulse(4'hE, mk(pw(0), BP0, 10'h044), "R11 ch0 untouched");
    check("R11 ch1", {8'h0, freq_o[63:32], phase_o[27:14], amp_o[19:10]}, mk(32'h9999_0000, BP1, BA1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule